// File: doc/BRIEF.md
# Password Verify and Attempt Counter

This block keeps a table of password sets, each holding one password that grants read access and one that grants read and write access. A host presents a candidate password with a set number and a password kind. The block compares it against the stored entry and reports the result one clock later. On a match it records which set and which kind is now active. On a mismatch it clears the active password and steps the attempts counter of the entry that was tried. Only one password is active at any time.

Each entry has its own 8-bit attempts counter. The counter moves through a fixed code in which one or two bits are cleared per failure. A configuration input selects either a four-trial code or an eight-trial code. A count of zero locks that entry for good. A correct presentation to an entry that is still alive restores its counter to full.

When supervisor mode is enabled, the write password of the highest-numbered set acts as a supervisor key. While that key is active, the host can rewrite any stored password or counter and can read back any stored password. Two resets are provided. `por_ni` loads the power-on contents. `rst_ni` ends the session and leaves the stored contents untouched.

Top module: `pwd_verify`

## Requirements
- R1: While `rst_ni` is low, `act_valid_o`, `vfy_done_o` and `vfy_ok_o` are 0. Stored passwords and counters keep their values across `rst_ni`.
- R2: `vfy_valid_i` is sampled at a rising clock edge. If `vfy_kind_i`=1 (write kind) and the write password of `vfy_set_i` equals `vfy_pw_i` and its counter is nonzero, then after that edge: `vfy_done_o`=1, `vfy_ok_o`=1, `act_valid_o`=1, `act_set_o`=`vfy_set_i` and `act_write_o`=1.
- R3: The same applies with `vfy_kind_i`=0 (read kind) against the read password, except that `act_write_o`=0.
- R4: The active state changes only on a presentation. A later successful presentation replaces the earlier one.
- R5: A failed presentation gives `vfy_done_o`=1 and `vfy_ok_o`=0, and it clears `act_valid_o`.
- R6: With `short_cnt_i`=1, failures on one entry step its counter FF, EE, CC, 88, 00.
- R7: With `short_cnt_i`=0, failures step the counter FF, FE, FC, F8, F0, E0, C0, 80, 00.
- R8: A counter at 00 sets that entry's bit in `dis_rd_o` or `dis_wr_o` (bit index = set). The correct password for that entry is then rejected. The counter stays 00, even after a supervisor write to it.
- R9: A successful presentation sets the entry's counter to FF.
- R10: `sup_o`=1 exactly while the active password is the write password of set NUM_SETS-1 and `sup_dis_i`=0. Writes on the `wr_*` port take effect only when `sup_o`=1 and `vfy_valid_i`=0. `wr_cnt_sel_i`=1 writes the counter from `wr_data_i[7:0]`, and `wr_cnt_sel_i`=0 writes the password. `rd_pw_o` shows the selected password only while `sup_o`=1 and reads 0 otherwise.
- R11: `por_ni` low loads every password with INIT_PW and every counter with FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, loads stored contents |
| rst_ni | input | 1 | Session reset, active low |
| short_cnt_i | input | 1 | 1 selects the four-trial counter code |
| sup_dis_i | input | 1 | 1 disables supervisor mode |
| vfy_valid_i | input | 1 | Present a password this cycle |
| vfy_set_i | input | SET_W | Password set to check |
| vfy_kind_i | input | 1 | 1 selects the write password, 0 the read password |
| vfy_pw_i | input | PW_W | Presented password |
| vfy_done_o | output | 1 | A presentation was evaluated on the last edge |
| vfy_ok_o | output | 1 | That presentation matched |
| act_valid_o | output | 1 | A password is active |
| act_set_o | output | SET_W | Active set |
| act_write_o | output | 1 | Active password is of the write kind |
| sup_o | output | 1 | Supervisor access granted |
| dis_rd_o | output | NUM_SETS | Read password locked, per set |
| dis_wr_o | output | NUM_SETS | Write password locked, per set |
| wr_en_i | input | 1 | Supervisor write strobe |
| wr_set_i | input | SET_W | Set to write |
| wr_kind_i | input | 1 | Kind to write |
| wr_cnt_sel_i | input | 1 | 1 writes the counter, 0 writes the password |
| wr_data_i | input | PW_W | Write data |
| rd_set_i | input | SET_W | Set to read back |
| rd_kind_i | input | 1 | Kind to read back |
| rd_cnt_o | output | 8 | Counter of the selected entry |
| rd_pw_o | output | PW_W | Password of the selected entry, 0 unless supervisor |

## Verification
The bench builds the block with its default values: eight sets, 24-bit passwords and the default INIT_PW. With these values, set 7 is the supervisor set, so the bench can open supervisor access using the power-on password. It then loads distinct passwords into several sets. Both counter codes are run all the way to lockout on separate entries, and supervisor writes are tried against a locked counter and with supervisor mode disabled.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_FULL = 8'hFF;

  typedef enum logic {KIND_RD = 1'b0, KIND_WR = 1'b1} pw_kind_e;

  // four-trial code clears one bit per nibble, eight-trial clears one bit
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input logic short_code);
    logic [CNT_W-1:0] sh;
    sh = {c[CNT_W-2:0], 1'b0};
    return short_code ? (sh & 8'hEE) : sh;
  endfunction
endpackage

// File: rtl/pwd_cnt_step.sv
module pwd_cnt_step
  import pwd_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             short_i,
  output logic [CNT_W-1:0] nxt_o
);
  always_comb nxt_o = cnt_step(cnt_i, short_i);
endmodule

// File: rtl/pwd_entry.sv
module pwd_entry
  import pwd_pkg::*;
#(
  parameter int          PW_W    = 24,
  parameter logic [23:0] INIT_PW = 24'hA5C3F0
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             short_i,
  input  logic             hit_i,
  input  logic [PW_W-1:0]  cmp_pw_i,
  input  logic             wr_pw_en_i,
  input  logic             wr_cnt_en_i,
  input  logic [PW_W-1:0]  wr_data_i,
  output logic             match_o,
  output logic             dead_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PW_W-1:0]  pw_o
);
  logic [PW_W-1:0]  pw_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  pwd_cnt_step u_step (.cnt_i(cnt_q), .short_i(short_i), .nxt_o(cnt_nxt));

  assign dead_o  = (cnt_q == '0);
  assign match_o = !dead_o && (pw_q == cmp_pw_i);
  assign cnt_o   = cnt_q;
  assign pw_o    = pw_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      pw_q  <= PW_W'(INIT_PW);
      cnt_q <= CNT_FULL;
    end else if (hit_i) begin
      if (match_o)      cnt_q <= CNT_FULL;
      else if (!dead_o) cnt_q <= cnt_nxt;
    end else begin
      if (wr_pw_en_i)             pw_q  <= wr_data_i;
      if (wr_cnt_en_i && !dead_o) cnt_q <= wr_data_i[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pwd_active.sv
module pwd_active #(
  parameter int SET_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vfy_valid_i,
  input  logic             ok_i,
  input  logic [SET_W-1:0] set_i,
  input  logic             kind_i,
  output logic             valid_o,
  output logic [SET_W-1:0] set_o,
  output logic             write_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      set_o   <= '0;
      write_o <= 1'b0;
    end else if (vfy_valid_i) begin
      valid_o <= ok_i;
      set_o   <= ok_i ? set_i : '0;
      write_o <= ok_i && kind_i;
    end
  end
endmodule

// File: rtl/pwd_verify.sv
module pwd_verify
  import pwd_pkg::*;
#(
  parameter int          NUM_SETS = 8,
  parameter int          PW_W     = 24,
  parameter logic [23:0] INIT_PW  = 24'hA5C3F0,
  localparam int         SET_W    = $clog2(NUM_SETS),
  localparam int         NUM_ENT  = 2 * NUM_SETS
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                rst_ni,
  input  logic                short_cnt_i,
  input  logic                sup_dis_i,
  input  logic                vfy_valid_i,
  input  logic [SET_W-1:0]    vfy_set_i,
  input  logic                vfy_kind_i,
  input  logic [PW_W-1:0]     vfy_pw_i,
  output logic                vfy_done_o,
  output logic                vfy_ok_o,
  output logic                act_valid_o,
  output logic [SET_W-1:0]    act_set_o,
  output logic                act_write_o,
  output logic                sup_o,
  output logic [NUM_SETS-1:0] dis_rd_o,
  output logic [NUM_SETS-1:0] dis_wr_o,
  input  logic                wr_en_i,
  input  logic [SET_W-1:0]    wr_set_i,
  input  logic                wr_kind_i,
  input  logic                wr_cnt_sel_i,
  input  logic [PW_W-1:0]     wr_data_i,
  input  logic [SET_W-1:0]    rd_set_i,
  input  logic                rd_kind_i,
  output logic [7:0]          rd_cnt_o,
  output logic [PW_W-1:0]     rd_pw_o
);
  localparam logic [SET_W-1:0] SUP_SET = SET_W'(NUM_SETS - 1);

  logic [NUM_ENT-1:0] match, dead;
  logic [CNT_W-1:0]   cnt [NUM_ENT];
  logic [PW_W-1:0]    pw  [NUM_ENT];
  logic [SET_W:0]     vfy_idx, wr_idx, rd_idx;
  logic               wr_ok, hit_ok;

  assign vfy_idx = {vfy_set_i, vfy_kind_i};
  assign wr_idx  = {wr_set_i, wr_kind_i};
  assign rd_idx  = {rd_set_i, rd_kind_i};
  assign hit_ok  = match[vfy_idx];
  assign sup_o   = act_valid_o && act_write_o && (act_set_o == SUP_SET) && !sup_dis_i;
  assign wr_ok   = wr_en_i && sup_o && !vfy_valid_i;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar k = 0; k < 2; k++) begin : g_kind
      localparam int E = 2 * s + k;
      logic sel_w;
      assign sel_w = wr_ok && (wr_idx == (SET_W+1)'(E));
      pwd_entry #(.PW_W(PW_W), .INIT_PW(INIT_PW)) u_ent (
        .clk_i      (clk_i),
        .por_ni     (por_ni),
        .short_i    (short_cnt_i),
        .hit_i      (vfy_valid_i && (vfy_idx == (SET_W+1)'(E))),
        .cmp_pw_i   (vfy_pw_i),
        .wr_pw_en_i (sel_w && !wr_cnt_sel_i),
        .wr_cnt_en_i(sel_w && wr_cnt_sel_i),
        .wr_data_i  (wr_data_i),
        .match_o    (match[E]),
        .dead_o     (dead[E]),
        .cnt_o      (cnt[E]),
        .pw_o       (pw[E])
      );
    end
    assign dis_rd_o[s] = dead[2*s];
    assign dis_wr_o[s] = dead[2*s+1];
  end

  pwd_active #(.SET_W(SET_W)) u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vfy_valid_i(vfy_valid_i),
    .ok_i       (hit_ok),
    .set_i      (vfy_set_i),
    .kind_i     (vfy_kind_i),
    .valid_o    (act_valid_o),
    .set_o      (act_set_o),
    .write_o    (act_write_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vfy_done_o <= 1'b0;
      vfy_ok_o   <= 1'b0;
    end else begin
      vfy_done_o <= vfy_valid_i;
      vfy_ok_o   <= vfy_valid_i && hit_ok;
    end
  end

  assign rd_cnt_o = cnt[rd_idx];
  assign rd_pw_o  = sup_o ? pw[rd_idx] : '0;
endmodule

// File: rtl/pwd_verify_chk.sv
module pwd_verify_chk #(
  parameter int NUM_SETS = 8,
  parameter int PW_W     = 24,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input logic                clk_i,
  input logic                por_ni,
  input logic                rst_ni,
  input logic                vfy_valid_i,
  input logic [SET_W-1:0]    vfy_set_i,
  input logic                vfy_kind_i,
  input logic                vfy_done_o,
  input logic                vfy_ok_o,
  input logic                act_valid_o,
  input logic [SET_W-1:0]    act_set_o,
  input logic                act_write_o,
  input logic                sup_o,
  input logic [NUM_SETS-1:0] dis_rd_o,
  input logic [NUM_SETS-1:0] dis_wr_o,
  input logic [PW_W-1:0]     rd_pw_o
);
  assert_ok_activates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    vfy_done_o && vfy_ok_o |-> act_valid_o && act_set_o == $past(vfy_set_i)
                               && act_write_o == $past(vfy_kind_i));

  assert_done_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    vfy_done_o |-> $past(vfy_valid_i));

  assert_fail_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    vfy_done_o && !vfy_ok_o |-> !act_valid_o);

  assert_active_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !$past(vfy_valid_i) |-> $stable(act_valid_o) && $stable(act_set_o) && $stable(act_write_o));

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
    ((dis_rd_o & $past(dis_rd_o)) == $past(dis_rd_o)) &&
    ((dis_wr_o & $past(dis_wr_o)) == $past(dis_wr_o)));

  assert_pw_hidden_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !sup_o |-> rd_pw_o == '0);
endmodule

bind pwd_verify pwd_verify_chk #(.NUM_SETS(NUM_SETS), .PW_W(PW_W)) u_chk (
  .clk_i(clk_i), .por_ni(por_ni), .rst_ni(rst_ni),
  .vfy_valid_i(vfy_valid_i), .vfy_set_i(vfy_set_i), .vfy_kind_i(vfy_kind_i),
  .vfy_done_o(vfy_done_o), .vfy_ok_o(vfy_ok_o),
  .act_valid_o(act_valid_o), .act_set_o(act_set_o), .act_write_o(act_write_o),
  .sup_o(sup_o), .dis_rd_o(dis_rd_o), .dis_wr_o(dis_wr_o), .rd_pw_o(rd_pw_o)
);

// File: tb/pwd_verify_tb.sv
module pwd_verify_tb;
  localparam int          NUM_SETS = 8;
  localparam int          PW_W     = 24;
  localparam logic [23:0] INIT_PW  = 24'hA5C3F0;
  localparam int          SET_W    = 3;

  logic clk = 1'b0;
  logic por_n = 1'b1, rst_n = 1'b1;
  logic short_cnt = 1'b0, sup_dis = 1'b0;
  logic vfy_valid = 1'b0, vfy_kind = 1'b0;
  logic [SET_W-1:0] vfy_set = '0;
  logic [PW_W-1:0]  vfy_pw = '0;
  logic vfy_done, vfy_ok, act_valid, act_write, sup;
  logic [SET_W-1:0] act_set;
  logic [NUM_SETS-1:0] dis_rd, dis_wr;
  logic wr_en = 1'b0, wr_kind = 1'b0, wr_cnt_sel = 1'b0;
  logic [SET_W-1:0] wr_set = '0, rd_set = '0;
  logic [PW_W-1:0] wr_data = '0;
  logic rd_kind = 1'b0;
  logic [7:0] rd_cnt;
  logic [PW_W-1:0] rd_pw;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwd_verify #(.NUM_SETS(NUM_SETS), .PW_W(PW_W), .INIT_PW(INIT_PW)) u_dut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .short_cnt_i(short_cnt),
    .sup_dis_i(sup_dis), .vfy_valid_i(vfy_valid), .vfy_set_i(vfy_set),
    .vfy_kind_i(vfy_kind), .vfy_pw_i(vfy_pw), .vfy_done_o(vfy_done),
    .vfy_ok_o(vfy_ok), .act_valid_o(act_valid), .act_set_o(act_set),
    .act_write_o(act_write), .sup_o(sup), .dis_rd_o(dis_rd), .dis_wr_o(dis_wr),
    .wr_en_i(wr_en), .wr_set_i(wr_set), .wr_kind_i(wr_kind),
    .wr_cnt_sel_i(wr_cnt_sel), .wr_data_i(wr_data), .rd_set_i(rd_set),
    .rd_kind_i(rd_kind), .rd_cnt_o(rd_cnt), .rd_pw_o(rd_pw)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on falling edge, result visible at next falling edge
  task automatic present(input int s, input bit k, input logic [PW_W-1:0] p);
    @(negedge clk);
    vfy_valid = 1'b1; vfy_set = SET_W'(s); vfy_kind = k; vfy_pw = p;
    @(negedge clk);
    vfy_valid = 1'b0;
  endtask

  task automatic sup_write(input int s, input bit k, input bit c, input logic [PW_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = SET_W'(s); wr_kind = k; wr_cnt_sel = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] cnt_of(input int s, input bit k);
    rd_set = SET_W'(s); rd_kind = k;
    return 8'h00;
  endfunction

  task automatic read_cnt(input int s, input bit k, output logic [7:0] v);
    rd_set = SET_W'(s); rd_kind = k; #1; v = rd_cnt;
  endtask

  task automatic read_pw(input int s, input bit k, output logic [PW_W-1:0] v);
    rd_set = SET_W'(s); rd_kind = k; #1; v = rd_pw;
  endtask

  task automatic t_reset_state;
    logic [7:0] c;
    logic [PW_W-1:0] p;
    #2 por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 act_valid in reset", 32'(act_valid), 0);
    check("R1 done in reset", 32'(vfy_done), 0);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    read_cnt(2, 1, c);  check("R11 counter loaded FF", 32'(c), 32'hFF);
    read_cnt(5, 0, c);  check("R11 counter loaded FF", 32'(c), 32'hFF);
    check("R11 no lockout", 32'({dis_rd, dis_wr}), 0);
    read_pw(0, 0, p);   check("R10 pw hidden w/o supervisor", 32'(p), 0);
  endtask

  task automatic t_supervisor_load;
    logic [PW_W-1:0] p;
    sup_write(0, 0, 0, 24'h111111);          // no supervisor: ignored
    present(7, 1, INIT_PW);
    check("R2 ok", 32'(vfy_ok), 1);
    check("R2 done", 32'(vfy_done), 1);
    check("R2 active set", 32'({act_valid, act_set, act_write}), 32'({1'b1, 3'd7, 1'b1}));
    check("R10 supervisor on", 32'(sup), 1);
    read_pw(0, 0, p); check("R10 write ignored w/o supervisor", 32'(p), 32'(INIT_PW));
    sup_write(0, 0, 0, 24'h111111);
    sup_write(0, 1, 0, 24'h222222);
    sup_write(3, 0, 0, 24'h333333);
    read_pw(0, 0, p); check("R10 pw written", 32'(p), 32'h111111);
    read_pw(3, 0, p); check("R10 pw written", 32'(p), 32'h333333);
    read_pw(0, 1, p); check("R10 pw written", 32'(p), 32'h222222);
  endtask

  task automatic t_read_and_replace;
    present(0, 0, 24'h111111);
    check("R3 read kind active", 32'({act_valid, act_set, act_write}), 32'({1'b1, 3'd0, 1'b0}));
    check("R10 supervisor dropped", 32'(sup), 0);
    repeat (3) @(negedge clk);
    check("R4 active held", 32'({act_valid, act_set}), 32'({1'b1, 3'd0}));
    present(3, 0, 24'h333333);
    check("R4 replaced", 32'({act_valid, act_set, act_write}), 32'({1'b1, 3'd3, 1'b0}));
  endtask

  task automatic t_long_code;
    logic [7:0] exp_seq [8] = '{8'hFE, 8'hFC, 8'hF8, 8'hF0, 8'hE0, 8'hC0, 8'h80, 8'h00};
    logic [7:0] c;
    short_cnt = 1'b0;
    for (int i = 0; i < 8; i++) begin
      present(3, 0, 24'h000BAD);
      if (i == 0) begin
        check("R5 fail ok low", 32'(vfy_ok), 0);
        check("R5 fail clears active", 32'(act_valid), 0);
      end
      read_cnt(3, 0, c); check("R7 eight-trial step", 32'(c), 32'(exp_seq[i]));
    end
    check("R8 lock flag", 32'(dis_rd[3]), 1);
    present(3, 0, 24'h333333);
    check("R8 correct rejected", 32'({vfy_done, vfy_ok, act_valid}), 32'b100);
    read_cnt(3, 0, c); check("R8 stays zero", 32'(c), 0);
  endtask

  task automatic t_short_code;
    logic [7:0] exp_seq [4] = '{8'hEE, 8'hCC, 8'h88, 8'h00};
    logic [7:0] c;
    short_cnt = 1'b1;
    present(0, 1, 24'h0);
    read_cnt(0, 1, c); check("R6 four-trial step", 32'(c), 32'hEE);
    present(0, 1, 24'h0);
    read_cnt(0, 1, c); check("R6 four-trial step", 32'(c), 32'hCC);
    present(0, 1, 24'h222222);
    check("R2 write kind ok", 32'({vfy_ok, act_set, act_write}), 32'({1'b1, 3'd0, 1'b1}));
    read_cnt(0, 1, c); check("R9 restored FF", 32'(c), 32'hFF);
    for (int i = 0; i < 4; i++) begin
      present(0, 1, 24'h123456);
      read_cnt(0, 1, c); check("R6 four-trial step", 32'(c), 32'(exp_seq[i]));
    end
    check("R8 write lock flag", 32'(dis_wr[0]), 1);
  endtask

  task automatic t_supervisor_gate;
    logic [7:0] c;
    logic [PW_W-1:0] p;
    sup_dis = 1'b1;
    present(7, 1, INIT_PW);
    check("R10 disabled: active but no supervisor", 32'({act_valid, sup}), 32'b10);
    read_pw(7, 1, p); check("R10 pw hidden when disabled", 32'(p), 0);
    sup_write(1, 0, 0, 24'h444444);
    sup_dis = 1'b0; #1;
    check("R10 supervisor enabled", 32'(sup), 1);
    read_pw(1, 0, p); check("R10 write ignored when disabled", 32'(p), 32'(INIT_PW));
    sup_write(3, 0, 1, 24'h0000FF);
    read_cnt(3, 0, c); check("R8 locked counter not revived", 32'(c), 0);
    sup_write(1, 0, 1, 24'h000080);
    read_cnt(1, 0, c); check("R10 counter written", 32'(c), 32'h80);
  endtask

  task automatic t_session_reset;
    logic [7:0] c;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears active", 32'({act_valid, sup}), 0);
    rst_n = 1'b1;
    read_cnt(3, 0, c); check("R1 counter kept", 32'(c), 0);
    read_cnt(1, 0, c); check("R1 counter kept", 32'(c), 32'h80);
    present(0, 0, 24'h111111);
    check("R1 password kept", 32'({vfy_ok, act_valid}), 32'b11);
  endtask

  initial begin
    t_reset_state();
    t_supervisor_load();
    t_read_and_replace();
    t_long_code();
    t_short_code();
    t_supervisor_gate();
    t_session_reset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule